// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block walks the column addresses of a single SDRAM read or write burst. A one-cycle start pulse captures a starting column together with a length code and an ordering choice. From the next cycle on, the block presents one column per clock with a valid flag, and it raises a last flag on the final beat. The controller around it turns each presented column into a column command, so back-to-back column accesses run at the one-cycle column-to-column spacing.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. They use either linear (wrapping increment) or XOR (interleaved) beat order. Full-page bursts walk the whole row, wrapping at the row end, until the controller asks them to stop. A start pulse that arrives while a burst is still running has no effect. A start pulse in the cycle that shows the last beat opens the next burst with no gap.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, valid_o and last_o are 0.
- R2: A start_i that is high at a rising edge while no burst is running launches a burst. In the next cycle valid_o is 1 and col_o equals the sampled start_col_i.
- R3: blen_i codes 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 beats, and codes 4, 5 and 6 also give 1 beat. valid_o is 1 on every beat, and last_o is 1 only on the final beat. A 1-beat burst raises last_o on its first beat.
- R4: When btype_i is 0 (linear) on a fixed burst of L beats, beat k shows the start column with its low log2(L) bits replaced by (start low bits + k) mod L. The upper bits stay unchanged.
- R5: When btype_i is 1 (XOR) on a fixed burst, beat k shows the start column XOR k.
- R6: blen_i code 7 selects full page. Beat k shows (start column + k) mod 2^COL_W, whatever the value of btype_i, and the burst continues without limit.
- R7: In a full-page burst, a stop_i that is high at a rising edge while the burst is running makes the beat of the next cycle the last one. A stop_i that is high at the launch edge has no effect.
- R8: stop_i has no effect during a fixed burst, which always delivers all of its beats.
- R9: A start_i that is high while a burst is running (valid_o high and last_o low) is ignored. The running burst keeps its column sequence.
- R10: blen_i, btype_i and start_col_i are used only at the launch edge. Changing them during a burst does not change its columns or length.
- R11: A start_i that is high in the cycle where last_o is 1 launches the next burst. Its first beat follows in the next cycle with no idle cycle between the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch request for a new burst |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Length code: 0/1/2/3 give 1/2/4/8 beats, 7 gives full page, other codes give 1 beat |
| btype_i | input | 1 | Beat ordering: 0 linear, 1 XOR |
| stop_i | input | 1 | Terminate a running full-page burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The presented beat is the final one |

## Verification
Fixed bursts are launched from start columns whose low bits sit at the bottom, middle and top of their aligned block. This separates a linear wrap from the XOR pattern, and it shows whether the upper column bits are held. Full-page runs start just below the row end so that the wrap to zero is visible. They are repeated with the XOR ordering selected, which must leave the result unchanged. Stop, start and mode changes are applied in the middle of a burst to show that each is ignored or acted on as required. A start input held high continuously shows that bursts chain with no gap.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  localparam logic [2:0] LEN_ONE  = 3'd0;
  localparam logic [2:0] LEN_TWO  = 3'd1;
  localparam logic [2:0] LEN_FOUR = 3'd2;
  localparam logic [2:0] LEN_EGHT = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

  // Beats delivered by a fixed-length code (full page returns 1, unused there)
  function automatic int unsigned beats_of(input logic [2:0] code);
    case (code)
      LEN_TWO:  return 2;
      LEN_FOUR: return 4;
      LEN_EGHT: return 8;
      default:  return 1;
    endcase
  endfunction

  function automatic logic is_page(input logic [2:0] code);
    return code == LEN_PAGE;
  endfunction

endpackage

// File: rtl/colseq_beat_ctr.sv
module colseq_beat_ctr
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [2:0]       blen_i,
  output logic [COL_W-1:0] beat_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             launch_o,
  output logic             running_o,
  output logic             page_o
);

  logic [COL_W-1:0] beat_q, last_idx_q, beat_nxt;
  logic             valid_q, last_q, page_q;

  assign running_o = valid_q & ~last_q;
  assign launch_o  = start_i & ~running_o;
  assign beat_nxt  = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q     <= '0;
      last_idx_q <= '0;
      valid_q    <= 1'b0;
      last_q     <= 1'b0;
      page_q     <= 1'b0;
    end else if (launch_o) begin
      beat_q     <= '0;
      last_idx_q <= COL_W'(beats_of(blen_i) - 1);
      valid_q    <= 1'b1;
      page_q     <= is_page(blen_i);
      last_q     <= !is_page(blen_i) && (beats_of(blen_i) == 1);
    end else if (running_o) begin
      beat_q     <= beat_nxt;
      last_q     <= page_q ? stop_i : (beat_nxt == last_idx_q);
    end else begin
      valid_q    <= 1'b0;
      last_q     <= 1'b0;
    end
  end

  assign beat_o  = beat_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;
  assign page_o  = page_q;

endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [2:0]       blen_i,
  input  order_e           order_i,
  input  logic             page_i,
  output logic [COL_W-1:0] col_o
);

  // Wrapping increment inside the aligned block selected by mask
  function automatic logic [COL_W-1:0] linear_col(input logic [COL_W-1:0] base,
                                                  input logic [COL_W-1:0] beat,
                                                  input logic [COL_W-1:0] mask);
    return (base & ~mask) | ((base + beat) & mask);
  endfunction

  function automatic logic [COL_W-1:0] xor_col(input logic [COL_W-1:0] base,
                                               input logic [COL_W-1:0] beat,
                                               input logic [COL_W-1:0] mask);
    return base ^ (beat & mask);
  endfunction

  function automatic logic [COL_W-1:0] page_col(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] beat);
    return base + beat;
  endfunction

  logic [COL_W-1:0] mask;
  assign mask = COL_W'(beats_of(blen_i) - 1);

  always_comb begin
    if (page_i)                 col_o = page_col(base_i, beat_i);
    else if (order_i == ORD_XOR) col_o = xor_col(base_i, beat_i, mask);
    else                        col_o = linear_col(base_i, beat_i, mask);
  end

endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
  import colseq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             btype_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] beat_w;
  logic             launch_w, running_w, fullpage_w;
  logic [COL_W-1:0] base_q;
  logic [2:0]       blen_q;
  order_e           order_q;

  colseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .blen_i   (blen_i),
    .beat_o   (beat_w),
    .valid_o  (valid_o),
    .last_o   (last_o),
    .launch_o (launch_w),
    .running_o(running_w),
    .page_o   (fullpage_w)
  );

  // Mode capture: only the launch edge looks at the mode inputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      blen_q  <= LEN_ONE;
      order_q <= ORD_LINEAR;
    end else if (launch_w) begin
      base_q  <= start_col_i;
      blen_q  <= blen_i;
      order_q <= order_e'(btype_i);
    end
  end

  colseq_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .beat_i (beat_w),
    .blen_i (blen_q),
    .order_i(order_q),
    .page_i (fullpage_w),
    .col_o  (col_o)
  );

endmodule

// File: rtl/colseq_checker.sv
module colseq_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       blen_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             launch_w,
  input logic             running_w,
  input logic             fullpage_w
);

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R3

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |=> (valid_o && col_o == $past(start_col_i))); // R2

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_w && blen_i == 3'd0) |=> last_o); // R3

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running_w && fullpage_w) |=> (col_o == $past(col_o) + {{(COL_W-1){1'b0}}, 1'b1})); // R6

  AST_PAGE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (running_w && fullpage_w && stop_i) |=> last_o); // R7

  AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (running_w && start_i) |=> (valid_o && !launch_w || last_o || valid_o)); // R9

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (running_w && !fullpage_w) |=> $stable(col_o[COL_W-1:3])); // R4

endmodule

bind sdram_burst_colseq colseq_checker #(.COL_W(COL_W)) u_colseq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .blen_i     (blen_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o),
  .launch_w   (launch_w),
  .running_w  (running_w),
  .fullpage_w (fullpage_w)
);

// File: tb/tb_sdram_burst_colseq.sv
module tb_sdram_burst_colseq;

  localparam int COL_W = 8;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = 3'd0;
  logic             btype_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sdram_burst_colseq #(.COL_W(COL_W)) dut (.*);

  // Behavioural reference: queue of pending fixed-burst columns, or a page walker
  int q[$];
  bit m_valid = 0, m_last = 0, m_page = 0, m_stop = 0;
  int m_col = 0, m_pcol = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_valid = 0; m_last = 0; m_page = 0; m_stop = 0; m_col = 0;
    end else begin
      bit busy;
      busy = m_valid && !m_last;
      if (start_i && !busy) begin
        int len, s;
        s = start_col_i;
        q.delete(); m_page = 0; m_stop = 0;
        if (blen_i == 3'd7) begin
          m_page = 1; m_pcol = s;
        end else begin
          len = (blen_i == 3'd1) ? 2 : (blen_i == 3'd2) ? 4 : (blen_i == 3'd3) ? 8 : 1;
          for (int k = 0; k < len; k++) begin
            if (btype_i) q.push_back(s ^ k);
            else q.push_back(s - (s % len) + ((s % len) + k) % len);
          end
        end
      end else if (busy && m_page && stop_i) begin
        m_stop = 1;
      end
      if (q.size() > 0) begin
        m_col = q.pop_front(); m_valid = 1; m_last = (q.size() == 0);
      end else if (m_page) begin
        m_col = m_pcol; m_pcol = (m_pcol + 1) % ROW; m_valid = 1; m_last = m_stop;
        if (m_stop) begin m_page = 0; m_stop = 0; end
      end else begin
        m_valid = 0; m_last = 0;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (valid_o !== m_valid || last_o !== m_last ||
          (m_valid && col_o !== COL_W'(m_col))) begin
        n_bad++;
        $display("FAIL %s t=%0t valid/last/col actual=%0b/%0b/%0h expected=%0b/%0b/%0h",
                 cur_req, $time, valid_o, last_o, col_o, m_valid, m_last, m_col[COL_W-1:0]);
      end
    end
  end

  task automatic launch(input string req, input logic [2:0] code, input logic ord,
                        input logic [COL_W-1:0] c, input int wait_cyc);
    cur_req = req;
    @(negedge clk);
    start_i = 1'b1; blen_i = code; btype_i = ord; start_col_i = c;
    @(negedge clk);
    start_i = 1'b0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset valid/last actual=%0b/%0b expected=0/0", valid_o, last_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    launch("R2", 3'd2, 1'b0, 8'h2D, 6);        // R4 linear wrap, 4 beats
    launch("R4", 3'd3, 1'b0, 8'h15, 10);       // R4 linear wrap, 8 beats
    launch("R4", 3'd3, 1'b0, 8'h08, 10);
    launch("R5", 3'd3, 1'b1, 8'h15, 10);       // R5 XOR order
    launch("R5", 3'd2, 1'b1, 8'hA2, 6);
    launch("R3", 3'd0, 1'b0, 8'h77, 3);        // R3 single beat
    launch("R3", 3'd1, 1'b0, 8'h33, 3);
    launch("R3", 3'd5, 1'b1, 8'h4C, 3);        // R3 unused code -> 1 beat

    // R6 / R7 full page crossing row end, then stop
    cur_req = "R6";
    @(negedge clk);
    start_i = 1'b1; blen_i = 3'd7; btype_i = 1'b0; start_col_i = 8'hFC; stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    repeat (9) @(negedge clk);
    cur_req = "R7"; stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    repeat (3) @(negedge clk);

    // R6 XOR ordering has no effect on full page; long run past the row
    launch("R6", 3'd7, 1'b1, 8'h81, 300);
    cur_req = "R7"; stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    repeat (3) @(negedge clk);

    // R8 stop during a fixed burst
    launch("R8", 3'd3, 1'b0, 8'h42, 2);
    stop_i = 1'b1;
    repeat (3) @(negedge clk);
    stop_i = 1'b0;
    repeat (6) @(negedge clk);

    // R9 and R10: start and mode changes mid-burst
    launch("R9", 3'd3, 1'b1, 8'h63, 2);
    start_i = 1'b1; start_col_i = 8'h10; blen_i = 3'd0; btype_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    cur_req = "R10"; blen_i = 3'd7; btype_i = 1'b0; start_col_i = 8'hEE;
    repeat (8) @(negedge clk);

    // R11 start held high: bursts chain without gaps
    cur_req = "R11";
    start_i = 1'b1; blen_i = 3'd2; btype_i = 1'b0; start_col_i = 8'h51;
    repeat (13) @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);

    finish_run();
  end

endmodule